// File: doc/BRIEF.md
# Command and Interrupt Control Core

This block is the host-facing control core of a network adapter. The host writes 16-bit command words to one fixed command port. Each word carries a 5-bit opcode in bits 15..11 and an 11-bit argument in bits 10..0. The core decodes the word and acts on it. It keeps the selected register window, the interrupt mask, the read-zero mask and the receive filter bits. It also issues one-cycle strobes that the receiver, the transmitter and the rest of the adapter consume.

Events from the datapath are caught in eight interrupt status latches. The host clears them by sending an acknowledge command whose argument is a bitmask. A 16-bit status word is readable at all times. It shows the window number, a command-busy flag and the latched bits, with the latched bits filtered by the read-zero mask. A level interrupt request is raised whenever a latched bit that the interrupt mask enables is set.

After each accepted command the core reports itself busy. Software polls the busy flag before it sends the next command. A write that arrives while the core is busy has no effect, and it sets a sticky error flag.

Top module: `hctl_core`

## Requirements
- R1: Opcode 1 selects the register window given by argument bits 2..0. The window number appears on `window_o` and in status bits 15..13 from the cycle after the accepting edge.
- R2: Status bit 12 is the busy flag. An accepted write sets it for `BUSY_RST_CYC` cycles (default 20) if the opcode is 0, 5 or 0x0B, and for exactly one cycle for any other opcode.
- R3: A write made while busy changes no state and sets `busy_err_o`. That flag stays set until an accepted global reset clears it.
- R4: An `ev_i[k]` pulse sets status latch k, for k in 1, 2, 3, 4, 5 and 7 (adapter failure, TX complete, TX available, RX complete, RX early, update statistics). `ev_i[0]` and `ev_i[6]` are ignored. Opcode 0x0C sets latch 6 (requested interrupt).
- R5: Opcode 0x0D (acknowledge) clears every latch whose bit is set in argument bits 7..0. If an event for a bit arrives in the same cycle as the acknowledge of that bit, the event wins and the bit stays set.
- R6: Opcode 0x0E loads the interrupt mask from argument bits 7..0. The mask is 0 after reset. `irq_o` is high exactly when some latched bit is set whose mask bit is also set.
- R7: Latch 0 (summary) becomes set whenever one of latches 1..7 is set and enabled by the mask. An acknowledge clears latch 0 only when no enabled source latch is left set.
- R8: Opcode 0x0F loads the read-zero mask from argument bits 7..0. The mask is all ones after reset. Status bits 7..0 equal the latches ANDed with this mask. `irq_o` does not depend on this mask.
- R9: Opcode 0x10 loads `filter_o` from argument bits 3..0: individual (bit 0), multicast (bit 1), broadcast (bit 2), promiscuous (bit 3).
- R10: Opcodes 3, 4 and 5 (receive disable, enable, reset) each pulse their strobe for one cycle after the accepting edge. `rx_on_o` is set by enable, is cleared by disable and reset, and is low after power-up.
- R11: Opcodes 9, 0x0A and 0x0B (transmit enable, disable, reset) work the same way on the transmit strobes and on `tx_on_o`.
- R12: Opcode 0 (global reset) pulses `gbl_rst_p`. It clears the window, the latches, the interrupt mask, the filter, `rx_on_o`, `tx_on_o` and `busy_err_o`, and it sets the read-zero mask back to all ones.
- R13: Status bits 11..8 always read 0. Opcodes 2, 8 and 0x11..0x1F change nothing except the one-cycle busy flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_we | input | 1 | Command write strobe |
| cmd_data | input | 16 | Command word: opcode in bits 15..11, argument in bits 10..0 |
| ev_i | input | 8 | Event pulses, bit-aligned with the status latches |
| status_o | output | 16 | Status word |
| window_o | output | 3 | Selected register window |
| irq_o | output | 1 | Level interrupt request |
| filter_o | output | 4 | Receive filter bits |
| busy_err_o | output | 1 | Sticky flag for a write made while busy |
| rx_on_o | output | 1 | Receiver enabled |
| tx_on_o | output | 1 | Transmitter enabled |
| gbl_rst_p | output | 1 | Global reset strobe |
| rx_enable_p | output | 1 | Receive enable strobe |
| rx_disable_p | output | 1 | Receive disable strobe |
| rx_reset_p | output | 1 | Receive reset strobe |
| tx_enable_p | output | 1 | Transmit enable strobe |
| tx_disable_p | output | 1 | Transmit disable strobe |
| tx_reset_p | output | 1 | Transmit reset strobe |

## Verification
Two updates can hit the same status latch in one clock cycle: an acknowledge command clearing a bit, and a datapath event setting that same bit. The bench drives an `ev_i` pulse and an acknowledge for the same bit in one cycle. It expects the bit to stay set, and it expects the summary latch to follow because that source is enabled. A second overlap is a write that lands while the flag from the previous command is still set. The bench judges that case by the unchanged window and the raised error flag.

// File: rtl/hctl_pkg.sv
package hctl_pkg;

   typedef enum logic [4:0] {
      OP_GLOBAL_RST = 5'h00,
      OP_WIN_SEL    = 5'h01,
      OP_RX_OFF     = 5'h03,
      OP_RX_ON      = 5'h04,
      OP_RX_RST     = 5'h05,
      OP_TX_ON      = 5'h09,
      OP_TX_OFF     = 5'h0A,
      OP_TX_RST     = 5'h0B,
      OP_IRQ_REQ    = 5'h0C,
      OP_IRQ_ACK    = 5'h0D,
      OP_IMASK      = 5'h0E,
      OP_RDMASK     = 5'h0F,
      OP_FILTER     = 5'h10
   } opcode_e;

   typedef struct packed {
      logic gbl;
      logic win;
      logic rx_off;
      logic rx_on;
      logic rx_rst;
      logic tx_on;
      logic tx_off;
      logic tx_rst;
      logic req;
      logic ack;
      logic imask;
      logic rdmask;
      logic filt;
      logic long_busy;
   } dec_t;

endpackage

// File: rtl/hctl_dec.sv
module hctl_dec #(
   parameter int OP_W  = 5,
   parameter int ARG_W = 11,
   localparam int CMD_W = OP_W + ARG_W
) (
   input  logic             we,
   input  logic             busy,
   input  logic [CMD_W-1:0] cmd,
   output logic             acc,
   output hctl_pkg::dec_t   dec
);
   import hctl_pkg::*;

   logic [OP_W-1:0] op;
   logic [ARG_W-1:0] unused_arg;

   assign op         = cmd[CMD_W-1 -: OP_W];
   assign unused_arg = cmd[ARG_W-1:0];
   assign acc        = we & ~busy;

   always_comb begin
      dec = '0;
      if (acc) begin
         case (op)
            OP_GLOBAL_RST: dec.gbl    = 1'b1;
            OP_WIN_SEL:    dec.win    = 1'b1;
            OP_RX_OFF:     dec.rx_off = 1'b1;
            OP_RX_ON:      dec.rx_on  = 1'b1;
            OP_RX_RST:     dec.rx_rst = 1'b1;
            OP_TX_ON:      dec.tx_on  = 1'b1;
            OP_TX_OFF:     dec.tx_off = 1'b1;
            OP_TX_RST:     dec.tx_rst = 1'b1;
            OP_IRQ_REQ:    dec.req    = 1'b1;
            OP_IRQ_ACK:    dec.ack    = 1'b1;
            OP_IMASK:      dec.imask  = 1'b1;
            OP_RDMASK:     dec.rdmask = 1'b1;
            OP_FILTER:     dec.filt   = 1'b1;
            default:       dec        = '0;
         endcase
         dec.long_busy = dec.gbl | dec.rx_rst | dec.tx_rst;
      end
   end
endmodule

// File: rtl/hctl_busy.sv
module hctl_busy #(
   parameter int LONG_CYC = 20,
   localparam int CNT_W   = $clog2(LONG_CYC + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic long_sel,
   output logic busy
);
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (load)
         cnt <= long_sel ? CNT_W'(LONG_CYC) : CNT_W'(1);
      else if (cnt != '0)
         cnt <= cnt - CNT_W'(1);
   end

   assign busy = (cnt != '0);
endmodule

// File: rtl/hctl_irq_bank.sv
module hctl_irq_bank #(
   parameter int N       = 8,
   parameter int SUM_BIT = 0,
   parameter int REQ_BIT = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] ev,
   input  logic         req,
   input  logic         ack,
   input  logic [N-1:0] ack_bits,
   input  logic         wipe,
   input  logic [N-1:0] imask,
   output logic [N-1:0] lat
);
   logic [N-1:0] raw;
   logic [N-1:0] nxt;
   logic         src_hit;
   logic [1:0]   unused_ev;

   assign unused_ev = {ev[SUM_BIT], ev[REQ_BIT]};

   for (genvar i = 0; i < N; i++) begin : g_bit
      logic keep;
      assign keep = lat[i] & ~(ack & ack_bits[i]);
      if (i == SUM_BIT) begin : g_sum
         assign raw[i] = 1'b0;
         assign nxt[i] = ~wipe & (keep | src_hit);
      end else if (i == REQ_BIT) begin : g_req
         assign raw[i] = ~wipe & (req | keep);
         assign nxt[i] = raw[i];
      end else begin : g_evt
         assign raw[i] = ~wipe & (ev[i] | keep);
         assign nxt[i] = raw[i];
      end
   end

   assign src_hit = |(raw & imask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lat <= '0;
      else        lat <= nxt;
   end
endmodule

// File: rtl/hctl_core.sv
module hctl_core #(
   parameter int OP_W         = 5,
   parameter int ARG_W        = 11,
   parameter int WIN_W        = 3,
   parameter int NUM_LAT      = 8,
   parameter int FILT_W       = 4,
   parameter int BUSY_RST_CYC = 20
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cmd_we,
   input  logic [15:0] cmd_data,
   input  logic [7:0]  ev_i,
   output logic [15:0] status_o,
   output logic [2:0]  window_o,
   output logic        irq_o,
   output logic [3:0]  filter_o,
   output logic        busy_err_o,
   output logic        rx_on_o,
   output logic        tx_on_o,
   output logic        gbl_rst_p,
   output logic        rx_enable_p,
   output logic        rx_disable_p,
   output logic        rx_reset_p,
   output logic        tx_enable_p,
   output logic        tx_disable_p,
   output logic        tx_reset_p
);
   import hctl_pkg::*;

   localparam int CMD_W  = OP_W + ARG_W;
   localparam int STAT_W = 16;
   localparam int RSV_W  = STAT_W - WIN_W - 1 - NUM_LAT;

   if (CMD_W != 16)        begin : g_bad_cmd  $error("command word must be 16 bits"); end
   if (WIN_W != 3)         begin : g_bad_win  $error("window field must be 3 bits"); end
   if (NUM_LAT != 8)       begin : g_bad_lat  $error("eight status latches expected"); end
   if (FILT_W > ARG_W)     begin : g_bad_filt $error("filter wider than argument"); end
   if (BUSY_RST_CYC < 2)   begin : g_bad_busy $error("reset busy time must exceed one cycle"); end

   logic               busy;
   logic               acc;
   dec_t               dec;
   logic [ARG_W-1:0]   arg;
   logic [NUM_LAT-1:0] lat;
   logic [NUM_LAT-1:0] imask_q;
   logic [NUM_LAT-1:0] rdmask_q;
   logic [WIN_W-1:0]   win_q;
   logic [FILT_W-1:0]  filt_q;
   logic               err_q;
   logic               rx_on_q;
   logic               tx_on_q;
   logic [6:0]         strobe_q;
   logic [ARG_W-1:0]   unused_arg_hi;

   assign arg           = cmd_data[ARG_W-1:0];
   assign unused_arg_hi = arg;

   hctl_dec #(.OP_W(OP_W), .ARG_W(ARG_W)) u_dec (
      .we   (cmd_we),
      .busy (busy),
      .cmd  (cmd_data),
      .acc  (acc),
      .dec  (dec)
   );

   hctl_busy #(.LONG_CYC(BUSY_RST_CYC)) u_busy (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (acc),
      .long_sel (dec.long_busy),
      .busy     (busy)
   );

   hctl_irq_bank #(.N(NUM_LAT), .SUM_BIT(0), .REQ_BIT(6)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .ev       (ev_i),
      .req      (dec.req),
      .ack      (dec.ack),
      .ack_bits (arg[NUM_LAT-1:0]),
      .wipe     (dec.gbl),
      .imask    (imask_q),
      .lat      (lat)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_q    <= '0;
         imask_q  <= '0;
         rdmask_q <= '1;
         filt_q   <= '0;
         err_q    <= 1'b0;
         rx_on_q  <= 1'b0;
         tx_on_q  <= 1'b0;
         strobe_q <= '0;
      end else begin
         strobe_q <= {dec.gbl, dec.rx_on, dec.rx_off, dec.rx_rst,
                      dec.tx_on, dec.tx_off, dec.tx_rst};
         if (dec.gbl) begin
            win_q    <= '0;
            imask_q  <= '0;
            rdmask_q <= '1;
            filt_q   <= '0;
            err_q    <= 1'b0;
            rx_on_q  <= 1'b0;
            tx_on_q  <= 1'b0;
         end else begin
            if (cmd_we && busy) err_q    <= 1'b1;
            if (dec.win)        win_q    <= arg[WIN_W-1:0];
            if (dec.imask)      imask_q  <= arg[NUM_LAT-1:0];
            if (dec.rdmask)     rdmask_q <= arg[NUM_LAT-1:0];
            if (dec.filt)       filt_q   <= arg[FILT_W-1:0];
            if (dec.rx_off || dec.rx_rst) rx_on_q <= 1'b0;
            else if (dec.rx_on)           rx_on_q <= 1'b1;
            if (dec.tx_off || dec.tx_rst) tx_on_q <= 1'b0;
            else if (dec.tx_on)           tx_on_q <= 1'b1;
         end
      end
   end

   assign status_o     = {win_q, busy, {RSV_W{1'b0}}, lat & rdmask_q};
   assign window_o     = win_q;
   assign irq_o        = |(lat & imask_q);
   assign filter_o     = filt_q;
   assign busy_err_o   = err_q;
   assign rx_on_o      = rx_on_q;
   assign tx_on_o      = tx_on_q;
   assign gbl_rst_p    = strobe_q[6];
   assign rx_enable_p  = strobe_q[5];
   assign rx_disable_p = strobe_q[4];
   assign rx_reset_p   = strobe_q[3];
   assign tx_enable_p  = strobe_q[2];
   assign tx_disable_p = strobe_q[1];
   assign tx_reset_p   = strobe_q[0];
endmodule

// File: rtl/hctl_core_chk.sv
module hctl_core_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        cmd_we,
   input logic [15:0] cmd_data,
   input logic [7:0]  ev_i,
   input logic [15:0] status_o,
   input logic [2:0]  window_o,
   input logic        irq_o,
   input logic        busy_err_o,
   input logic        rx_on_o,
   input logic        rx_enable_p,
   input logic        rx_disable_p,
   input logic        rx_reset_p
);
   logic accepted;
   logic rejected;
   assign accepted = cmd_we && !status_o[12];
   assign rejected = cmd_we &&  status_o[12];

   // R2
   busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      accepted |=> status_o[12]);

   // R1
   window_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accepted && cmd_data[15:11] == 5'h01) |=> window_o == $past(cmd_data[2:0]));

   // R3
   busy_write_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rejected |=> busy_err_o);

   // R3
   busy_write_noeffect_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rejected |=> $stable(window_o));

   // R10
   rx_strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rx_enable_p, rx_disable_p, rx_reset_p}));

   // R10
   rx_on_after_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accepted && cmd_data[15:11] == 5'h04) |=> rx_on_o);

   // R5
   ack_all_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accepted && cmd_data[15:11] == 5'h0D && cmd_data[7:0] == 8'hFF && ev_i == 8'h00)
      |=> !irq_o);

   // R12
   global_reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accepted && cmd_data[15:11] == 5'h00) |=> (window_o == 3'd0 && !irq_o && !busy_err_o));
endmodule

bind hctl_core hctl_core_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cmd_we       (cmd_we),
   .cmd_data     (cmd_data),
   .ev_i         (ev_i),
   .status_o     (status_o),
   .window_o     (window_o),
   .irq_o        (irq_o),
   .busy_err_o   (busy_err_o),
   .rx_on_o      (rx_on_o),
   .rx_enable_p  (rx_enable_p),
   .rx_disable_p (rx_disable_p),
   .rx_reset_p   (rx_reset_p)
);

// File: tb/hctl_core_tb.sv
module hctl_core_tb;
   localparam int LONG = 20;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_we = 1'b0;
   logic [15:0] cmd_data = '0;
   logic [7:0]  ev_i = '0;
   logic [15:0] status_o;
   logic [2:0]  window_o;
   logic        irq_o, busy_err_o, rx_on_o, tx_on_o;
   logic [3:0]  filter_o;
   logic        gbl_rst_p, rx_enable_p, rx_disable_p, rx_reset_p;
   logic        tx_enable_p, tx_disable_p, tx_reset_p;

   int checks = 0;
   int failures = 0;
   int cyc = 0;

   always #4 clk = ~clk;

   hctl_core #(.BUSY_RST_CYC(LONG)) u_dut (
      .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_data(cmd_data), .ev_i(ev_i),
      .status_o(status_o), .window_o(window_o), .irq_o(irq_o), .filter_o(filter_o),
      .busy_err_o(busy_err_o), .rx_on_o(rx_on_o), .tx_on_o(tx_on_o),
      .gbl_rst_p(gbl_rst_p), .rx_enable_p(rx_enable_p), .rx_disable_p(rx_disable_p),
      .rx_reset_p(rx_reset_p), .tx_enable_p(tx_enable_p), .tx_disable_p(tx_disable_p),
      .tx_reset_p(tx_reset_p)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == 100000) begin
         failures++;
         $display("FAIL watchdog actual=%0d expected=<100000 cycles", cyc);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic idle();
      while (status_o[12]) @(negedge clk);
   endtask

   task automatic wr_ev(input logic [4:0] op, input logic [10:0] arg, input logic [7:0] ev);
      idle();
      cmd_we = 1'b1; cmd_data = {op, arg}; ev_i = ev;
      @(negedge clk);
      cmd_we = 1'b0; ev_i = '0;
   endtask

   task automatic wr(input logic [4:0] op, input logic [10:0] arg);
      wr_ev(op, arg, 8'h00);
   endtask

   task automatic pulse_ev(input logic [7:0] ev);
      ev_i = ev;
      @(negedge clk);
      ev_i = '0;
   endtask

   task automatic t_reset();
      chk("R13 reset status", status_o, 16'h0000);
      chk("R10 rx off at reset", {15'd0, rx_on_o}, 16'd0);
      chk("R6 irq low at reset", {15'd0, irq_o}, 16'd0);
   endtask

   task automatic t_window();
      wr(5'h01, 11'h7FD);
      chk("R1 window port", {13'd0, window_o}, 16'd5);
      chk("R1 status window+busy", status_o, 16'hB000);
      @(negedge clk);
      chk("R2 short busy ends", {15'd0, status_o[12]}, 16'd0);
   endtask

   task automatic t_busy_err();
      wr(5'h01, 11'h002);
      cmd_we = 1'b1; cmd_data = {5'h01, 11'h007};
      @(negedge clk);
      cmd_we = 1'b0;
      chk("R3 window unchanged", {13'd0, window_o}, 16'd2);
      chk("R3 error flag", {15'd0, busy_err_o}, 16'd1);
   endtask

   task automatic t_rx();
      wr(5'h04, 11'h000);
      chk("R10 enable strobe", {13'd0, rx_enable_p, rx_disable_p, rx_reset_p}, 16'd4);
      chk("R10 rx on", {15'd0, rx_on_o}, 16'd1);
      @(negedge clk);
      chk("R10 strobe one cycle", {15'd0, rx_enable_p}, 16'd0);
      wr(5'h05, 11'h000);
      chk("R10 reset strobe", {13'd0, rx_enable_p, rx_disable_p, rx_reset_p}, 16'd1);
      chk("R10 rx off by reset", {15'd0, rx_on_o}, 16'd0);
      repeat (LONG - 1) @(negedge clk);
      chk("R2 long busy last cycle", {15'd0, status_o[12]}, 16'd1);
      @(negedge clk);
      chk("R2 long busy over", {15'd0, status_o[12]}, 16'd0);
      wr(5'h04, 11'h000);
      wr(5'h03, 11'h000);
      chk("R10 disable strobe", {13'd0, rx_enable_p, rx_disable_p, rx_reset_p}, 16'd2);
      chk("R10 rx off by disable", {15'd0, rx_on_o}, 16'd0);
   endtask

   task automatic t_tx();
      wr(5'h09, 11'h000);
      chk("R11 tx enable", {14'd0, tx_enable_p, tx_on_o}, 16'd3);
      wr(5'h0A, 11'h000);
      chk("R11 tx disable", {14'd0, tx_disable_p, tx_on_o}, 16'd2);
      wr(5'h09, 11'h000);
      wr(5'h0B, 11'h000);
      chk("R11 tx reset", {14'd0, tx_reset_p, tx_on_o}, 16'd2);
   endtask

   task automatic t_events();
      wr(5'h0E, 11'h0BE);
      @(negedge clk);
      pulse_ev(8'h55);
      chk("R4 events latched", {8'd0, status_o[7:0]}, 16'h0015);
      chk("R6 irq raised", {15'd0, irq_o}, 16'd1);
      wr(5'h0D, 11'h004);
      chk("R7 summary held by bit4", {8'd0, status_o[7:0]}, 16'h0011);
      wr(5'h0D, 11'h011);
      chk("R5 ack clears", {8'd0, status_o[7:0]}, 16'h0000);
      chk("R6 irq drops", {15'd0, irq_o}, 16'd0);
   endtask

   task automatic t_collide();
      wr_ev(5'h0D, 11'h008, 8'h08);
      chk("R5 event beats ack", {8'd0, status_o[7:0]}, 16'h0009);
      wr(5'h0D, 11'h0FF);
      chk("R5 ack all", {8'd0, status_o[7:0]}, 16'h0000);
   endtask

   task automatic t_req();
      wr(5'h0C, 11'h000);
      chk("R4 request sets bit6", {8'd0, status_o[7:0]}, 16'h0040);
      chk("R6 masked request no irq", {15'd0, irq_o}, 16'd0);
      wr(5'h0E, 11'h040);
      chk("R6 unmasked request irq", {15'd0, irq_o}, 16'd1);
      wr(5'h0D, 11'h0FF);
      wr(5'h0E, 11'h0BE);
      @(negedge clk);
      chk("R5 request cleared", {8'd0, status_o[7:0]}, 16'h0000);
   endtask

   task automatic t_rdmask();
      pulse_ev(8'h20);
      chk("R4 rx early", {8'd0, status_o[7:0]}, 16'h0021);
      wr(5'h0F, 11'h000);
      chk("R8 hidden", {8'd0, status_o[7:0]}, 16'h0000);
      chk("R8 irq kept", {15'd0, irq_o}, 16'd1);
      wr(5'h0F, 11'h0FF);
      chk("R8 shown again", {8'd0, status_o[7:0]}, 16'h0021);
      wr(5'h0D, 11'h0FF);
   endtask

   task automatic t_filter_nop();
      wr(5'h10, 11'h7F5);
      chk("R9 filter", {12'd0, filter_o}, 16'h0005);
      wr(5'h02, 11'h7FF);
      chk("R13 nop keeps state", status_o, 16'h5000);
      chk("R13 nop keeps filter", {12'd0, filter_o}, 16'h0005);
      wr(5'h11, 11'h7FF);
      @(negedge clk);
      chk("R13 reserved opcode", status_o, 16'h4000);
   endtask

   task automatic t_global();
      wr(5'h01, 11'h003);
      wr(5'h04, 11'h000);
      wr(5'h0E, 11'h0FF);
      wr(5'h0F, 11'h00F);
      wr(5'h00, 11'h7FF);
      chk("R12 strobe", {15'd0, gbl_rst_p}, 16'd1);
      chk("R12 status cleared", status_o, 16'h1000);
      chk("R12 outputs cleared", {10'd0, filter_o, rx_on_o, busy_err_o}, 16'd0);
      repeat (LONG - 1) @(negedge clk);
      chk("R2 global busy last cycle", {15'd0, status_o[12]}, 16'd1);
      @(negedge clk);
      pulse_ev(8'h20);
      chk("R12 masks restored", {8'd0, status_o[7:0]}, 16'h0020);
      chk("R12 imask cleared", {15'd0, irq_o}, 16'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_window();
      t_busy_err();
      t_rx();
      t_tx();
      t_events();
      t_collide();
      t_req();
      t_rdmask();
      t_filter_nop();
      t_global();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule